// File: doc/BRIEF.md
# Interleaved-Map TDM Time-Slot Selector

This block sits on the receive side of a multiplexed TDM port. One serial stream runs at 8.192 Mb/s on a 16.384 MHz clock, so every data bit takes two clock cycles. A frame holds 128 eight-bit time slots. A frame pulse marks the first bit of slot 0. The block follows that pulse to keep its phase, bit and slot position. It then decides, for each received bit, whether the slot that bit belongs to is assigned.

Four link registers of 32 bits each make up the assignment map. They are interleaved bit by bit. Slot `n` belongs to link `n mod 4` and is enabled by bit `n div 4` of that link's register. Each sampled bit is presented together with its slot number and its owning link. A strobe qualifies the bit when its slot is enabled.

A frame pulse that comes at any point other than the natural end of a frame is reported, and the count realigns to it. When the four links do not share the same mode field, the block reports it and selects nothing.

Top module: `tdm_slot_selector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bit_valid`, `bit_out`, `slot_num`, `link_idx`, `frame_err` and `cfg_err` are all 0.
- R2: Until the first frame pulse after reset has been seen, `bit_valid` stays 0 whatever the map holds.
- R3: With `fp_active_low`=0 the pulse is a high level; with 1 it is a low level. A frame starts in the cycle in which the pulse level first becomes asserted after a cycle where it was not.
- R4: The frame-start cycle is phase 0 of bit 0 of slot 0. Each bit takes two clocks. The data is sampled in the second clock of the bit, and the results appear on the outputs one cycle later. So `bit_valid` is never high in two consecutive cycles.
- R5: For each sampled bit, `slot_num` gives the slot (0 to 127). `link_idx` gives slot mod 4.
- R6: The map bit for slot `n` is `map_regs[(n mod 4)*32 + (n div 4)]`. Link `k` occupies `map_regs[32k+31:32k]`. `bit_valid` is 1 exactly for sampled bits whose map bit is 1.
- R7: The position wraps after 2048 clocks. A pulse at that wrap point raises no error. A frame with no pulse runs on with the same selection.
- R8: A pulse at any other position makes `frame_err` high for exactly one cycle, aligned with the outputs of that cycle. The pulse cycle becomes position 0.
- R9: `link_cfg` holds four 4-bit mode fields, with link `k` at bits `[4k+3:4k]`. If any field differs from link 0's, then `cfg_err` is 1 and `bit_valid` is 0 in the same output cycle.
- R10: When `bit_valid` is 1, `bit_out` equals `sdata_in` as it was in the second clock of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate bit clock (16.384 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| fp_active_low | input | 1 | Frame pulse polarity: 0 active high, 1 active low |
| fp_in | input | 1 | Frame pulse |
| sdata_in | input | 1 | Serial data |
| map_regs | input | 128 | Four 32-bit link slot maps, link k at [32k+31:32k] |
| link_cfg | input | 16 | Four 4-bit link mode fields, link k at [4k+3:4k] |
| bit_out | output | 1 | Sampled data bit |
| bit_valid | output | 1 | Strobe: bit_out belongs to an enabled slot |
| slot_num | output | 7 | Slot of the latest sampled bit |
| link_idx | output | 2 | Link owning that slot |
| frame_err | output | 1 | One-cycle flag for a misplaced frame pulse |
| cfg_err | output | 1 | Link mode fields disagree |

## Verification
The bench builds the block with its default parameters: four links of 32 map bits, eight bits per slot and two clocks per bit. This gives a full 2048-clock frame. Slot 127 (link 3, map bit 31) and the natural wrap are therefore both reachable, as are single-slot maps in any link and a misplaced pulse in the middle of a frame. Both pulse polarities, a frame with no pulse, and a mode mismatch between links are exercised at this size.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    localparam int DEF_LINKS         = 4;
    localparam int DEF_MAP_BITS      = 32;
    localparam int DEF_BITS_PER_SLOT = 8;
    localparam int DEF_CLKS_PER_BIT  = 2;
    localparam int DEF_CFG_W         = 4;

    typedef enum logic {
        FP_HIGH = 1'b0,
        FP_LOW  = 1'b1
    } fp_pol_e;

    // Flat map bit that enables slot n in the interleaved layout
    function automatic int map_src_bit(input int n, input int nlinks, input int mbits);
        return (n % nlinks) * mbits + (n / nlinks);
    endfunction

endpackage

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
    import tdm_sel_pkg::*;
#(
    parameter int CLKS_PER_BIT  = DEF_CLKS_PER_BIT,
    parameter int BITS_PER_SLOT = DEF_BITS_PER_SLOT,
    parameter int SLOTS         = DEF_LINKS * DEF_MAP_BITS,
    parameter int PH_W          = $clog2(CLKS_PER_BIT),
    parameter int BIT_W         = $clog2(BITS_PER_SLOT),
    parameter int SLOT_W        = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_in,
    input  logic              fp_active_low,
    output logic              sample_now,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              misplaced
);

    fp_pol_e pol;
    logic    fp_n, fp_prev, sof, aligned, pos_ok;

    logic [PH_W-1:0]   ph_q,   ph_c,   ph_d;
    logic [BIT_W-1:0]  bit_q,  bit_c,  bit_d;
    logic [SLOT_W-1:0] slot_q, slot_c, slot_d;
    logic              ph_last, bit_last, slot_last;

    assign pol  = fp_pol_e'(fp_active_low);
    assign fp_n = (pol == FP_LOW) ? ~fp_in : fp_in;
    assign sof  = fp_n & ~fp_prev;

    // Position of the current cycle: a frame start forces zero
    assign ph_c   = sof ? '0 : ph_q;
    assign bit_c  = sof ? '0 : bit_q;
    assign slot_c = sof ? '0 : slot_q;

    assign ph_last   = (ph_c   == PH_W'(CLKS_PER_BIT - 1));
    assign bit_last  = (bit_c  == BIT_W'(BITS_PER_SLOT - 1));
    assign slot_last = (slot_c == SLOT_W'(SLOTS - 1));

    always_comb begin
        ph_d   = ph_last ? '0 : ph_c + 1'b1;
        bit_d  = bit_c;
        slot_d = slot_c;
        if (ph_last) begin
            bit_d = bit_last ? '0 : bit_c + 1'b1;
            if (bit_last)
                slot_d = slot_last ? '0 : slot_c + 1'b1;
        end
    end

    assign pos_ok     = aligned | sof;
    assign sample_now = pos_ok & ph_last;
    assign cur_slot   = slot_c;
    assign misplaced  = sof & aligned & ((|ph_q) | (|bit_q) | (|slot_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            fp_prev <= 1'b0;
            aligned <= 1'b0;
            ph_q    <= '0;
            bit_q   <= '0;
            slot_q  <= '0;
        end else begin
            fp_prev <= fp_n;
            if (sof)
                aligned <= 1'b1;
            if (pos_ok) begin
                ph_q   <= ph_d;
                bit_q  <= bit_d;
                slot_q <= slot_d;
            end
        end
    end

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_sel_pkg::*;
#(
    parameter int NUM_LINKS = DEF_LINKS,
    parameter int MAP_BITS  = DEF_MAP_BITS,
    parameter int SLOTS     = NUM_LINKS * MAP_BITS,
    parameter int SLOT_W    = $clog2(SLOTS),
    parameter int LINK_W    = $clog2(NUM_LINKS)
) (
    input  logic [NUM_LINKS*MAP_BITS-1:0] map_regs,
    input  logic [SLOT_W-1:0]             slot,
    output logic                          hit,
    output logic [LINK_W-1:0]             owner
);

    logic [SLOTS-1:0] merged;

    for (genvar n = 0; n < SLOTS; n++) begin : g_merge
        assign merged[n] = map_regs[map_src_bit(n, NUM_LINKS, MAP_BITS)];
    end

    assign hit   = merged[slot];
    assign owner = slot[LINK_W-1:0];

endmodule

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
    import tdm_sel_pkg::*;
#(
    parameter int NUM_LINKS = DEF_LINKS,
    parameter int CFG_W     = DEF_CFG_W
) (
    input  logic [NUM_LINKS*CFG_W-1:0] link_cfg,
    output logic                       mismatch
);

    logic [NUM_LINKS-2:0] differs;

    for (genvar k = 1; k < NUM_LINKS; k++) begin : g_cmp
        assign differs[k-1] = (link_cfg[k*CFG_W +: CFG_W] != link_cfg[0 +: CFG_W]);
    end

    assign mismatch = |differs;

endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector
    import tdm_sel_pkg::*;
#(
    parameter int NUM_LINKS     = DEF_LINKS,
    parameter int MAP_BITS      = DEF_MAP_BITS,
    parameter int BITS_PER_SLOT = DEF_BITS_PER_SLOT,
    parameter int CLKS_PER_BIT  = DEF_CLKS_PER_BIT,
    parameter int CFG_W         = DEF_CFG_W,
    localparam int SLOTS        = NUM_LINKS * MAP_BITS,
    localparam int SLOT_W       = $clog2(SLOTS),
    localparam int LINK_W       = $clog2(NUM_LINKS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fp_active_low,
    input  logic                          fp_in,
    input  logic                          sdata_in,
    input  logic [NUM_LINKS*MAP_BITS-1:0] map_regs,
    input  logic [NUM_LINKS*CFG_W-1:0]    link_cfg,
    output logic                          bit_out,
    output logic                          bit_valid,
    output logic [SLOT_W-1:0]             slot_num,
    output logic [LINK_W-1:0]             link_idx,
    output logic                          frame_err,
    output logic                          cfg_err
);

    typedef struct packed {
        logic              valid;
        logic              data;
        logic [SLOT_W-1:0] slot;
        logic [LINK_W-1:0] link;
        logic              ferr;
        logic              cerr;
    } beat_t;

    logic              sample_now, misplaced, hit, mismatch;
    logic [SLOT_W-1:0] cur_slot;
    logic [LINK_W-1:0] owner;
    beat_t             beat_q;

    tdm_frame_aligner #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .BITS_PER_SLOT(BITS_PER_SLOT),
        .SLOTS        (SLOTS)
    ) i_align (
        .clk          (clk),
        .rst          (rst),
        .fp_in        (fp_in),
        .fp_active_low(fp_active_low),
        .sample_now   (sample_now),
        .cur_slot     (cur_slot),
        .misplaced    (misplaced)
    );

    tdm_slot_map #(
        .NUM_LINKS(NUM_LINKS),
        .MAP_BITS (MAP_BITS)
    ) i_map (
        .map_regs(map_regs),
        .slot    (cur_slot),
        .hit     (hit),
        .owner   (owner)
    );

    tdm_cfg_check #(
        .NUM_LINKS(NUM_LINKS),
        .CFG_W    (CFG_W)
    ) i_cfg (
        .link_cfg(link_cfg),
        .mismatch(mismatch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.ferr  <= misplaced;
            beat_q.cerr  <= mismatch;
            beat_q.valid <= sample_now & hit & ~mismatch;
            if (sample_now) begin
                beat_q.data <= sdata_in;
                beat_q.slot <= cur_slot;
                beat_q.link <= owner;
            end
        end
    end

    assign bit_out   = beat_q.data;
    assign bit_valid = beat_q.valid;
    assign slot_num  = beat_q.slot;
    assign link_idx  = beat_q.link;
    assign frame_err = beat_q.ferr;
    assign cfg_err   = beat_q.cerr;

endmodule

// File: rtl/tdm_slot_selector_chk.sv
module tdm_slot_selector_chk #(
    parameter int NUM_LINKS = 4,
    parameter int MAP_BITS  = 32,
    parameter int SLOT_W    = 7,
    parameter int LINK_W    = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_LINKS*MAP_BITS-1:0] map_regs,
    input logic                          bit_valid,
    input logic [SLOT_W-1:0]             slot_num,
    input logic [LINK_W-1:0]             link_idx,
    input logic                          frame_err,
    input logic                          cfg_err
);

    logic [NUM_LINKS*MAP_BITS-1:0] map_q;
    logic [SLOT_W-1:0]             map_idx;

    always_ff @(posedge clk) map_q <= map_regs;

    assign map_idx = {link_idx, slot_num[SLOT_W-1:LINK_W]};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!bit_valid && !frame_err && !cfg_err));

    assert_valid_gap_R4: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    assert_valid_map_R6: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> map_q[map_idx]);

    assert_ferr_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_cfg_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !bit_valid);

endmodule

bind tdm_slot_selector tdm_slot_selector_chk #(
    .NUM_LINKS(NUM_LINKS),
    .MAP_BITS (MAP_BITS),
    .SLOT_W   (SLOT_W),
    .LINK_W   (LINK_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .map_regs (map_regs),
    .bit_valid(bit_valid),
    .slot_num (slot_num),
    .link_idx (link_idx),
    .frame_err(frame_err),
    .cfg_err  (cfg_err)
);

// File: tb/test_tdm_slot_selector.sv
module test_tdm_slot_selector;

    localparam int FRAME = 2048;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fp_active_low = 1'b0;
    logic         fp_in = 1'b0;
    logic         sdata_in = 1'b0;
    logic [127:0] map_regs = '0;
    logic [15:0]  link_cfg = 16'h6666;
    logic         bit_out, bit_valid, frame_err, cfg_err;
    logic [6:0]   slot_num;
    logic [1:0]   link_idx;

    always #2 clk = ~clk;

    tdm_slot_selector i_tdm_slot_selector (
        .clk(clk), .rst(rst), .fp_active_low(fp_active_low), .fp_in(fp_in),
        .sdata_in(sdata_in), .map_regs(map_regs), .link_cfg(link_cfg),
        .bit_out(bit_out), .bit_valid(bit_valid), .slot_num(slot_num),
        .link_idx(link_idx), .frame_err(frame_err), .cfg_err(cfg_err)
    );

    // bit 128 = polarity, bits 127:0 = map
    localparam logic [128:0] VEC [5] = '{
        {1'b0, {128{1'b1}}},
        {1'b0, 128'h1 << 35},
        {1'b1, 96'h0, 32'hFFFF_FFFF},
        {1'b1, 128'h1 << 127},
        {1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210}
    };

    int tests = 0, fails = 0;
    bit done = 0;

    // bench model state
    bit          pol = 0, prev_a = 0, aligned = 0;
    int          cnt = 0;
    logic [127:0] map_next = '0;
    logic [15:0]  cfg_next = 16'h6666;
    logic [7:0]   lf = 8'h01;
    bit          p_chk = 0, p_vexp, p_samp, p_ferr, p_cerr, p_d;
    int          p_slot;
    string       p_tag;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit fp_a, input string vtag);
        bit sof, pos_ok, mism;
        int pos;
        @(negedge clk);
        if (p_chk) begin
            chk(bit_valid == p_vexp, p_tag, bit_valid, p_vexp);
            chk(frame_err == p_ferr, "R8", frame_err, p_ferr);
            chk(cfg_err == p_cerr, "R9", cfg_err, p_cerr);
            if (p_samp) begin
                chk(slot_num == p_slot, "R5", slot_num, p_slot);
                chk(link_idx == p_slot % 4, "R5", link_idx, p_slot % 4);
                if (p_vexp) chk(bit_out == p_d, "R10", bit_out, p_d);
            end
        end
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        sdata_in      = lf[0];
        fp_active_low = pol;
        fp_in         = pol ? !fp_a : fp_a;
        map_regs      = map_next;
        link_cfg      = cfg_next;
        sof    = fp_a && !prev_a;
        prev_a = fp_a;
        p_ferr = sof && aligned && (cnt != 0);
        pos    = sof ? 0 : cnt;
        pos_ok = aligned || sof;
        p_samp = pos_ok && (pos % 2 == 1);
        p_slot = pos / 16;
        mism = 0;
        for (int k = 1; k < 4; k++)
            if (link_cfg[4*k +: 4] != link_cfg[3:0]) mism = 1;
        p_cerr = mism;
        p_vexp = p_samp && !mism && map_regs[(p_slot % 4) * 32 + p_slot / 4];
        p_d    = lf[0];
        p_tag  = vtag;
        p_chk  = 1;
        if (sof) aligned = 1;
        if (pos_ok) cnt = (pos + 1) % FRAME;
    endtask

    task automatic run_frame(input int len, input bit with_fp, input string vtag);
        for (int p = 0; p < len; p++) step(with_fp && p == 0, vtag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; fp_in = pol; p_chk = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        aligned = 0; cnt = 0; prev_a = 0;
        @(negedge clk);
        // R1: all outputs cleared
        chk({bit_valid, bit_out, slot_num, link_idx, frame_err, cfg_err} == '0,
            "R1", {bit_valid, bit_out, slot_num, link_idx, frame_err, cfg_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: no strobe before the first frame pulse
        map_next = {128{1'b1}};
        run_frame(300, 0, "R2");
        // Table walk: one aligned frame per vector (pulse at wrap, R7)
        for (int i = 0; i < 5; i++) begin
            map_next = VEC[i][127:0];
            pol      = VEC[i][128];
            run_frame(FRAME, 1, pol ? "R3" : (i == 0 ? "R4" : "R6"));
        end
        // R7: frame without a pulse keeps running
        map_next = VEC[4][127:0];
        pol = 0;
        run_frame(FRAME, 0, "R7");
        run_frame(FRAME, 1, "R7");
        // R8: misplaced pulse mid-frame realigns
        run_frame(700, 1, "R8");
        run_frame(FRAME, 1, "R8");
        run_frame(FRAME, 1, "R8");
        // R9: mode fields disagree
        cfg_next = 16'h6636;
        run_frame(FRAME, 1, "R9");
        cfg_next = 16'h6666;
        run_frame(FRAME, 1, "R9");
        // R1: reset in the middle of an aligned frame, then R2 again
        run_frame(500, 1, "R6");
        do_reset();
        run_frame(200, 0, "R2");
        pol = 1;
        map_next = {128{1'b1}};
        run_frame(FRAME, 1, "R3");
        step(0, "R3");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule